// File: doc/BRIEF.md
# Maskable interrupt acceptance controller

This block decides, once per instruction boundary, whether a small 8-bit CPU core may take an interrupt, and which one. It keeps a master enable flag and one enable flag for each maskable source numbered 3 to 38. Software reaches them through five byte-wide registers on a simple read/write bus, and a read-modify-write is an ordinary read followed by a write. Request latches live outside the block. It sees their state and returns a one-hot clear for the winning source.

Four pseudo non-maskable sources bypass every enable bit and always win over maskable ones. When an interrupt is taken, the block presents the current master flag so the core can push it, then clears the flag. Strobes from the core drive the flag from the enable, disable, maskable-return and non-maskable-return instructions. The non-maskable return restores the popped value.

Top module: `intr_accept_ctrl`

## Requirements
- R1: After reset the master flag and every enable flag are 0: all five registers read 0x00 and no maskable request is accepted.
- R2: A maskable request from source n is accepted only when the master flag is 1 and the enable flag for n is 1.
- R3: A pending pseudo non-maskable request is accepted at a boundary whatever the enable flags and the master flag hold. It takes precedence over all maskable requests, with index 0 (software) before 1 (undefined instruction) before 2 (address trap) before 3 (watchdog); `acc_pnm` is 1 for these.
- R4: In the accepting cycle `stack_imf` shows the master flag value held before acceptance, and from the next cycle the master flag is 0.
- R5: `reti_stb` sets the master flag to 1, and a request that is already pending and enabled is accepted in the very next cycle that has a boundary.
- R6: `retn_stb` loads the master flag from `retn_imf`, so the flag returns to 0 or to 1 according to the stacked value.
- R7: `ei_stb` sets the master flag and `di_stb` clears it. When strobes coincide, the order of precedence is acceptance, disable, enable, maskable return, non-maskable return, bus write.
- R8: Register map: address 0x3A holds the master flag in bit 0 and sources 1 to 7 in bits 1 to 7. Address 0x3B holds sources 8 to 15, 0x2C holds 16 to 23, 0x2D holds 24 to 31 and 0x2A holds 32 to 39, with bit k standing for source 8*byte+k. Sources 1, 2 and 39 do not exist; their bits read 0 and ignore writes. Any other address reads 0x00.
- R9: Among enabled maskable requests, the lowest source index wins.
- R10: For each acceptance, `acc_pulse` is high for exactly one cycle, together with a one-hot clear for the winning source on `req_clr` or `pnm_clr`. A bus write to the master-flag bit in the same cycle as an acceptance loses to the clear.
- R11: Nothing is accepted in a cycle where `inst_boundary` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| req_pend | input | 39 | Maskable request latches, bit n for source n |
| pnm_req | input | 4 | Pseudo non-maskable requests (software, undefined, trap, watchdog) |
| inst_boundary | input | 1 | Core is between instructions |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| reti_stb | input | 1 | Maskable return strobe |
| retn_stb | input | 1 | Non-maskable return strobe |
| retn_imf | input | 1 | Master flag value popped from the stack |
| acc_pulse | output | 1 | Interrupt accepted this cycle |
| acc_pnm | output | 1 | Accepted source is pseudo non-maskable |
| acc_idx | output | 6 | Winning source index |
| stack_imf | output | 1 | Master flag value to push |
| req_clr | output | 39 | One-hot clear of the winning maskable latch |
| pnm_clr | output | 4 | One-hot clear of the winning pseudo non-maskable request |

## Verification
On every cycle the assertions check several properties. Every maskable acceptance happens with the master flag set, a pending pseudo non-maskable request at a boundary is always taken, and nothing is taken off a boundary. The clears stay one-hot and agree with the pulse, and each strobe leaves the master flag at its required value one cycle later. The bench scenarios must show the rest: the register map with its missing bits, lowest-index and pseudo non-maskable precedence across several request patterns, immediate acceptance after a maskable return, and a bus write losing to an acceptance in the same cycle.

// File: rtl/intr_acc_pkg.sv
package intr_acc_pkg;
  localparam int ADDR_W  = 8;
  localparam int EF_LO   = 3;
  localparam int EF_HI   = 38;
  localparam int NPNM    = 4;
  localparam int IDX_W   = 6;
  localparam int NBYTES  = 5;
  // byte 0 first; byte b holds source indices 8*b .. 8*b+7
  localparam logic [ADDR_W*NBYTES-1:0] BYTE_ADDRS =
    {8'h2A, 8'h2D, 8'h2C, 8'h3B, 8'h3A};
endpackage

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] vld,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i]) idx = W'(i);
    end
    grant = vld & (~vld + N'(1));
    any   = |vld;
  end
endmodule

// File: rtl/intr_sfr_file.sv
module intr_sfr_file #(
  parameter int ADDR_W = 8,
  parameter int EF_LO  = 3,
  parameter int EF_HI  = 38,
  parameter int NBYTES = 5,
  parameter logic [ADDR_W*NBYTES-1:0] BYTE_ADDRS = {8'h2A, 8'h2D, 8'h2C, 8'h3B, 8'h3A}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              imf,
  output logic [7:0]        rdata,
  output logic [EF_HI:0]    ef,
  output logic              imf_wr_en,
  output logic              imf_wr_val
);
  localparam int NBITS = 8 * NBYTES;

  function automatic logic [NBITS-1:0] impl_mask();
    logic [NBITS-1:0] m;
    for (int i = 0; i < NBITS; i++) m[i] = (i >= EF_LO) && (i <= EF_HI);
    return m;
  endfunction
  localparam logic [NBITS-1:0] IMPL = impl_mask();

  logic [NBYTES-1:0] hit;
  logic [NBITS-1:0]  ef_q, ef_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_dec
    assign hit[b] = (addr == BYTE_ADDRS[b*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    ef_d = ef_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr && hit[b]) ef_d[b*8 +: 8] = wdata;
    end
    ef_d = ef_d & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ef_q <= '0;
    else        ef_q <= ef_d;
  end

  always_comb begin
    rdata = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (hit[b]) rdata = ef_q[b*8 +: 8] | ((b == 0) ? {7'b0, imf} : 8'h00);
    end
  end

  assign ef         = ef_q[EF_HI:0];
  assign imf_wr_en  = wr && hit[0];
  assign imf_wr_val = wdata[0];
endmodule

// File: rtl/intr_master_flag.sv
module intr_master_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic di,
  input  logic ei,
  input  logic reti,
  input  logic retn,
  input  logic retn_val,
  input  logic bus_en,
  input  logic bus_val,
  output logic imf
);
  logic imf_d;

  always_comb begin
    if      (accept) imf_d = 1'b0;
    else if (di)     imf_d = 1'b0;
    else if (ei)     imf_d = 1'b1;
    else if (reti)   imf_d = 1'b1;
    else if (retn)   imf_d = retn_val;
    else if (bus_en) imf_d = bus_val;
    else             imf_d = imf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imf <= 1'b0;
    else        imf <= imf_d;
  end

  p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !imf);
  p_di_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> !imf);
  p_ei_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ei && !accept && !di) |=> imf);
  p_reti_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !accept && !di && !ei) |=> imf);
  p_retn_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retn && !accept && !di && !ei && !reti) |=> (imf == $past(retn_val)));
endmodule

// File: rtl/intr_accept_ctrl.sv
module intr_accept_ctrl
  import intr_acc_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_EF_LO  = EF_LO,
  parameter int P_EF_HI  = EF_HI,
  parameter int P_NPNM   = NPNM,
  parameter int P_IDX_W  = IDX_W,
  parameter int P_NBYTES = NBYTES,
  parameter logic [P_ADDR_W*P_NBYTES-1:0] P_BYTE_ADDRS = BYTE_ADDRS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [P_EF_HI:0]    req_pend,
  input  logic [P_NPNM-1:0]   pnm_req,
  input  logic                inst_boundary,
  input  logic                ei_stb,
  input  logic                di_stb,
  input  logic                reti_stb,
  input  logic                retn_stb,
  input  logic                retn_imf,
  output logic                acc_pulse,
  output logic                acc_pnm,
  output logic [P_IDX_W-1:0]  acc_idx,
  output logic                stack_imf,
  output logic [P_EF_HI:0]    req_clr,
  output logic [P_NPNM-1:0]   pnm_clr
);
  localparam int PNM_W = (P_NPNM > 1) ? $clog2(P_NPNM) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic               imf;
  logic [P_EF_HI:0]   ef;
  logic               imf_wr_en, imf_wr_val;
  logic [P_EF_HI:0]   msk_vld, msk_grant;
  logic [P_IDX_W-1:0] msk_idx;
  logic               msk_any;
  logic [P_NPNM-1:0]  pnm_grant;
  logic [PNM_W-1:0]   pnm_idx;
  logic               pnm_any;
  logic               take;

  intr_sfr_file #(
    .ADDR_W(P_ADDR_W), .EF_LO(P_EF_LO), .EF_HI(P_EF_HI),
    .NBYTES(P_NBYTES), .BYTE_ADDRS(P_BYTE_ADDRS)
  ) u_sfr (
    .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .imf(imf), .rdata(bus_rdata), .ef(ef),
    .imf_wr_en(imf_wr_en), .imf_wr_val(imf_wr_val)
  );

  assign msk_vld = req_pend & ef & {(P_EF_HI+1){imf}};

  intr_lowest_pick #(.N(P_EF_HI+1), .W(P_IDX_W)) u_msk_pick (
    .vld(msk_vld), .any(msk_any), .idx(msk_idx), .grant(msk_grant)
  );

  intr_lowest_pick #(.N(P_NPNM), .W(PNM_W)) u_pnm_pick (
    .vld(pnm_req), .any(pnm_any), .idx(pnm_idx), .grant(pnm_grant)
  );

  always_comb begin
    take      = inst_boundary && (pnm_any || msk_any);
    acc_pulse = take;
    acc_pnm   = inst_boundary && pnm_any;
    acc_idx   = '0;
    req_clr   = '0;
    pnm_clr   = '0;
    if (inst_boundary && pnm_any) begin
      acc_idx = P_IDX_W'(pnm_idx);
      pnm_clr = pnm_grant;
    end else if (inst_boundary && msk_any) begin
      acc_idx = msk_idx;
      req_clr = msk_grant;
    end
    stack_imf = imf;
  end

  intr_master_flag u_imf (
    .clk(clk), .rst_n(rst_int_n), .accept(take), .di(di_stb), .ei(ei_stb),
    .reti(reti_stb), .retn(retn_stb), .retn_val(retn_imf),
    .bus_en(imf_wr_en), .bus_val(imf_wr_val), .imf(imf)
  );

  p_masked_needs_imf_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_pulse && !acc_pnm) |-> (imf && |(req_pend & ef)));
  p_pnm_always_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inst_boundary && |pnm_req) |-> (acc_pulse && acc_pnm));
  p_only_boundary_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_pulse |-> inst_boundary);
  p_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({req_clr, pnm_clr}) && (acc_pulse == |{req_clr, pnm_clr}));
endmodule

// File: tb/intr_accept_ctrl_bench.sv
module intr_accept_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr;
  logic [38:0] req_pend, req_clr;
  logic [3:0]  pnm_req, pnm_clr;
  logic        inst_boundary, ei_stb, di_stb, reti_stb, retn_stb, retn_imf;
  logic        acc_pulse, acc_pnm, stack_imf;
  logic [5:0]  acc_idx;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  intr_accept_ctrl u_intr_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_pend(req_pend),
    .pnm_req(pnm_req), .inst_boundary(inst_boundary), .ei_stb(ei_stb),
    .di_stb(di_stb), .reti_stb(reti_stb), .retn_stb(retn_stb),
    .retn_imf(retn_imf), .acc_pulse(acc_pulse), .acc_pnm(acc_pnm),
    .acc_idx(acc_idx), .stack_imf(stack_imf), .req_clr(req_clr),
    .pnm_clr(pnm_clr)
  );

  typedef struct packed {
    logic [3:0]  pnm;
    logic [38:0] req;
    logic        imf;
    logic        acc;
    logic        apnm;
    logic [5:0]  idx;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 39'h20,           1'b0, 1'b0, 1'b0, 6'd0},   // R2 master off
    '{4'h0, 39'h20,           1'b1, 1'b1, 1'b0, 6'd5},   // R2
    '{4'h0, 39'h100400,       1'b1, 1'b1, 1'b0, 6'd20},  // R2 EF10 off
    '{4'h0, 39'h4000000008,   1'b1, 1'b1, 1'b0, 6'd3},   // R9
    '{4'h8, 39'h0,            1'b0, 1'b1, 1'b1, 6'd3},   // R3 watchdog
    '{4'h6, 39'h10,           1'b1, 1'b1, 1'b1, 6'd1},   // R3 order
    '{4'h0, 39'h7,            1'b1, 1'b0, 1'b0, 6'd0},   // R8 no such sources
    '{4'h0, 39'h4000000000,   1'b1, 1'b1, 1'b0, 6'd38},  // R9 top source
    '{4'h1, 39'h20,           1'b0, 1'b1, 1'b1, 6'd0}    // R3 software first
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == e, tag, 64'(bus_rdata), 64'(e));
  endtask

  task automatic pulse_ei(input bit set);
    @(negedge clk);
    ei_stb = set; di_stb = !set;
    @(negedge clk);
    ei_stb = 1'b0; di_stb = 1'b0;
  endtask

  task automatic idle_inputs();
    req_pend = '0; pnm_req = '0; inst_boundary = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
    ei_stb = 0; di_stb = 0; reti_stb = 0; retn_stb = 0; retn_imf = 0;
    idle_inputs();
    #20 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    read_chk(8'h3A, 8'h00, "R1 reg 3A");
    read_chk(8'h3B, 8'h00, "R1 reg 3B");
    read_chk(8'h2C, 8'h00, "R1 reg 2C");
    read_chk(8'h2D, 8'h00, "R1 reg 2D");
    read_chk(8'h2A, 8'h00, "R1 reg 2A");
    req_pend = 39'h7FFFFFFFF8; inst_boundary = 1'b1; #1;
    chk(acc_pulse == 1'b0, "R1 no accept after reset", 64'(acc_pulse), 64'd0);
    idle_inputs();

    // R8: register map and missing bits
    bus_write(8'h3A, 8'hFE); read_chk(8'h3A, 8'hF8, "R8 reg 3A");
    bus_write(8'h3B, 8'hFF); read_chk(8'h3B, 8'hFF, "R8 reg 3B");
    bus_write(8'h2C, 8'hFF); read_chk(8'h2C, 8'hFF, "R8 reg 2C");
    bus_write(8'h2D, 8'hFF); read_chk(8'h2D, 8'hFF, "R8 reg 2D");
    bus_write(8'h2A, 8'hFF); read_chk(8'h2A, 8'h7F, "R8 reg 2A");
    bus_write(8'h3C, 8'hFF); read_chk(8'h3C, 8'h00, "R8 unmapped");
    bus_write(8'h3A, 8'h01); read_chk(8'h3A, 8'h01, "R8 master bit");
    bus_write(8'h3A, 8'hFE); read_chk(8'h3A, 8'hF8, "R8 master bit clear");
    bus_write(8'h3B, 8'hFB); read_chk(8'h3B, 8'hFB, "R8 EF10 off");

    // vector table
    for (int v = 0; v < NV; v++) begin
      pulse_ei(VECS[v].imf);
      req_pend = VECS[v].req; pnm_req = VECS[v].pnm; inst_boundary = 1'b1;
      #2;
      chk(acc_pulse == VECS[v].acc, $sformatf("R2 R3 R9 vec%0d pulse", v),
          64'(acc_pulse), 64'(VECS[v].acc));
      chk(stack_imf == VECS[v].imf, $sformatf("R4 vec%0d stack", v),
          64'(stack_imf), 64'(VECS[v].imf));
      if (VECS[v].acc) begin
        chk(acc_pnm == VECS[v].apnm, $sformatf("R3 vec%0d kind", v),
            64'(acc_pnm), 64'(VECS[v].apnm));
        chk(acc_idx == VECS[v].idx, $sformatf("R9 R3 vec%0d idx", v),
            64'(acc_idx), 64'(VECS[v].idx));
        if (VECS[v].apnm)
          chk(pnm_clr == (4'b1 << VECS[v].idx) && req_clr == '0,
              $sformatf("R10 vec%0d pnm clear", v), 64'(pnm_clr),
              64'(4'b1 << VECS[v].idx));
        else
          chk(req_clr == (39'b1 << VECS[v].idx) && pnm_clr == '0,
              $sformatf("R10 vec%0d req clear", v), 64'(req_clr),
              64'(39'b1 << VECS[v].idx));
      end
      @(negedge clk);
      idle_inputs();
      read_chk(8'h3A, {7'h7C, VECS[v].acc ? 1'b0 : VECS[v].imf},
               $sformatf("R4 vec%0d master after", v));
    end

    // R7: enable / disable strobes
    pulse_ei(1'b1); read_chk(8'h3A, 8'hF9, "R7 ei sets");
    pulse_ei(1'b0); read_chk(8'h3A, 8'hF8, "R7 di clears");

    // R11: no acceptance off a boundary
    pulse_ei(1'b1);
    req_pend = 39'h20; inst_boundary = 1'b0; #2;
    chk(acc_pulse == 1'b0, "R11 off boundary", 64'(acc_pulse), 64'd0);
    @(negedge clk); inst_boundary = 1'b1; #2;
    chk(acc_pulse == 1'b1 && acc_idx == 6'd5, "R11 on boundary", 64'(acc_idx), 64'd5);
    @(negedge clk); idle_inputs();

    // R5: maskable return makes a pending request acceptable at once
    pulse_ei(1'b0);
    req_pend = 39'h20; inst_boundary = 1'b1; #2;
    chk(acc_pulse == 1'b0, "R5 held while master off", 64'(acc_pulse), 64'd0);
    @(negedge clk); reti_stb = 1'b1;
    @(negedge clk); reti_stb = 1'b0; #2;
    chk(acc_pulse == 1'b1 && acc_idx == 6'd5, "R5 taken after return",
        64'(acc_pulse), 64'd1);
    @(negedge clk); idle_inputs();

    // R6: non-maskable return restores the stacked flag
    pulse_ei(1'b1);
    pnm_req = 4'h4; inst_boundary = 1'b1; #2;
    chk(stack_imf == 1'b1 && acc_pnm == 1'b1, "R6 stacked one", 64'(stack_imf), 64'd1);
    @(negedge clk); idle_inputs();
    read_chk(8'h3A, 8'hF8, "R4 cleared by pnm accept");
    retn_stb = 1'b1; retn_imf = 1'b1;
    @(negedge clk); retn_stb = 1'b0; retn_imf = 1'b0;
    read_chk(8'h3A, 8'hF9, "R6 restored to one");
    pulse_ei(1'b0);
    pnm_req = 4'h2; inst_boundary = 1'b1; #2;
    chk(stack_imf == 1'b0 && acc_pnm == 1'b1, "R6 stacked zero", 64'(stack_imf), 64'd0);
    @(negedge clk); idle_inputs();
    retn_stb = 1'b1; retn_imf = 1'b0;
    @(negedge clk); retn_stb = 1'b0;
    read_chk(8'h3A, 8'hF8, "R6 stays zero");

    // R10: single-cycle pulse, bus write to master bit loses to accept
    pulse_ei(1'b1);
    req_pend = 39'h20; inst_boundary = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h3A; bus_wdata = 8'hFF; #2;
    chk(acc_pulse == 1'b1, "R10 accept with write", 64'(acc_pulse), 64'd1);
    @(negedge clk); bus_wr = 1'b0; #2;
    chk(acc_pulse == 1'b0, "R10 pulse one cycle", 64'(acc_pulse), 64'd0);
    read_chk(8'h3A, 8'hF8, "R10 write lost to accept");
    idle_inputs();

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule